// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small eight-opcode processor. A microprogram counter selects one word of a twenty-word microcode store. That word's control fields drive the datapath directly during the cycle. On each clock edge the counter moves to the next microaddress, which the word's sequencing field selects.

There are four ways to pick the next address:
- an unconditional jump;
- a two-way branch on the memory wait line;
- a two-way branch on the ALU carry out;
- a dispatch that adds the instruction opcode to a fixed base.

Words 0 to 3 fetch a two-byte instruction, with a stall on wait in each read word. Word 4 dispatches. Words 5 to 12 are the entry points of opcodes 0 to 7, in order. Extra words after these carry the branch, store and load tails. The register file, ALU and memory sit outside this block.

The control outputs are combinational from the counter. A datapath samples them on the same edge that advances the sequencer.

Top module: `mseq_top`

## Requirements
- R1: While rst_ni is low, upc_o is 0 without waiting for a clock edge. Word 0 then drives a_sel_o=7, b_sel_o=7, alu_op_o=4 (AND), mar_ld_o=1, and reg_wr_o=8'h40 (bit n of reg_wr_o enables register n).
- R2: With mem_wait_i low, the counter steps through 0, 1, 2, 3, 4. Words 1 and 3 both assert mem_rd_o, alu_cin_o and reg_wr_o=8'h80. Word 1 loads the low instruction byte (ir_lo_ld_o) and word 3 loads the high one (ir_hi_ld_o). At most one of ir_lo_ld_o, ir_hi_ld_o and mem_wr_o is high at a time.
- R3: In the wait-looping words (1, 3, 17, 18), a high mem_wait_i at a clock edge keeps the counter on the same word.
- R4: From word 4, the next address is 5 plus opcode_i.
- R5: In word 8 (branch if zero), alu_op_o is 3 (decrement A), res_src_o is 2 (4-bit constant), srca_ir_o=1 and reg_wr_o=8'h40. The next word is 0 when alu_cout_i is 1, and 13 otherwise. Word 13 drives a_sel_o=7, b_sel_o=6, alu_op_o=0 (ADD) and reg_wr_o=8'h80, then returns to 0.
- R6: A store visits 10, 15, 16, 17 and then 0. Word 10 drives mar_ld_o with srca_ir_o and alu_op_o=1 (pass A). Word 16 drives mdr_src_o=1 (from ALU), srcb_ir_o and alu_op_o=5 (OR). Word 17 drives mem_wr_o with mem_rd_o low.
- R7: A load visits 11, 18, 19 and then 0. Word 18 drives mem_rd_o and mdr_src_o=2 (from memory). Word 19 drives res_src_o=3 (memory data) and dst_ir_o.
- R8: Words 6, 7, 9 and 12 each return to 0 after one cycle, with these outputs:

  | Word | Operation | alu_op_o | alu_cin_o | res_src_o | Register fields from the instruction |
  |---|---|---|---|---|---|
  | 6 | add | 0 | — | — | destination, A and B |
  | 7 | 8-bit constant | — | — | 1 | destination only |
  | 9 | move | 1 | — | — | destination and A, not B |
  | 12 | subtract | 2 | 1 | — | destination, A and B |

- R9: Word 5 (no-op) drives every control output to 0 and returns to 0. The unused word 14 also drives all zeros and returns to 0. Any address at or above the store depth goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_wait_i | input | 1 | Memory not ready; stalls the read and write words |
| alu_cout_i | input | 1 | ALU carry out, used by branch if zero |
| opcode_i | input | 3 | Opcode field of the instruction register |
| upc_o | output | 5 | Current microaddress |
| a_sel_o | output | 3 | A-port register select |
| b_sel_o | output | 3 | B-port register select |
| alu_op_o | output | 3 | ALU operation: 0 ADD, 1 pass A, 2 SUB, 3 decrement A, 4 AND, 5 OR |
| alu_cin_o | output | 1 | ALU carry in |
| reg_wr_o | output | 8 | Per-register write enables |
| dst_ir_o | output | 1 | Destination register taken from the instruction |
| srca_ir_o | output | 1 | A-port register taken from the instruction |
| srcb_ir_o | output | 1 | B-port register taken from the instruction |
| mar_ld_o | output | 1 | Load the memory address register |
| mdr_src_o | output | 2 | Memory data register load: 0 none, 1 ALU, 2 memory |
| ir_lo_ld_o | output | 1 | Load the first instruction byte |
| ir_hi_ld_o | output | 1 | Load the second instruction byte |
| res_src_o | output | 2 | Result source: 0 ALU, 1 8-bit constant, 2 4-bit constant, 3 memory data |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |

## Verification
The bench walks each opcode's full address trail, starting at fetch, and holds wait high for several cycles in every looping word.
- A sequencer that ignored wait would run ahead of memory.
- One that stalled on the wrong words would hang or skip a word.
- Both branch-if-zero outcomes are driven. A sequencer with the carry sense inverted would take the branch on a nonzero register.
- All eight dispatch targets are covered. An off-by-one dispatch base would run the wrong operation's controls, and the per-word field checks catch this.
- A reset asserted in the middle of fetch must clear the counter at once. A synchronous or missing reset would not.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UA_W = 5;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_PASS = 3'd1, ALU_SUB = 3'd2,
    ALU_DEC = 3'd3, ALU_AND = 3'd4, ALU_OR = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    RES_ALU = 2'd0, RES_K8 = 2'd1, RES_K4 = 2'd2, RES_MDR = 2'd3
  } res_src_e;

  typedef enum logic [1:0] {
    MDR_NONE = 2'd0, MDR_ALU = 2'd1, MDR_MEM = 2'd2
  } mdr_src_e;

  typedef enum logic [1:0] {
    NX_GOTO = 2'd0, NX_WAIT = 2'd1, NX_COUT = 2'd2, NX_DISP = 2'd3
  } nxt_e;

  typedef struct packed {
    logic [2:0]      a_sel;
    logic [2:0]      b_sel;
    alu_op_e         alu;
    logic            cin;
    logic [7:0]      reg_wr;
    logic            dst_ir;
    logic            srca_ir;
    logic            srcb_ir;
    logic            mar_ld;
    mdr_src_e        mdr;
    logic            ir_lo;
    logic            ir_hi;
    res_src_e        res;
    logic            rd;
    logic            wr;
    nxt_e            nxt;
    logic [UA_W-1:0] tgt_t;  // goto / condition true
    logic [UA_W-1:0] tgt_f;  // condition false
  } uword_t;
endpackage

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic [UA_W-1:0] addr_i,
  output uword_t          word_o
);
  uword_t w;

  always_comb begin
    w = '0;
    case (addr_i)
      5'd0, 5'd2: begin  // copy PC to r6, address memory
        w.a_sel = 3'd7; w.b_sel = 3'd7; w.alu = ALU_AND;
        w.reg_wr = 8'h40; w.mar_ld = 1'b1;
        w.nxt = NX_GOTO; w.tgt_t = addr_i + 5'd1;
      end
      5'd1, 5'd3: begin  // read byte, bump PC
        w.a_sel = 3'd6; w.alu = ALU_PASS; w.cin = 1'b1;
        w.reg_wr = 8'h80; w.rd = 1'b1;
        w.ir_lo = (addr_i == 5'd1); w.ir_hi = (addr_i == 5'd3);
        w.nxt = NX_WAIT; w.tgt_t = addr_i; w.tgt_f = addr_i + 5'd1;
      end
      5'd4:  w.nxt = NX_DISP;
      5'd6: begin
        w.dst_ir = 1'b1; w.srca_ir = 1'b1; w.srcb_ir = 1'b1; w.alu = ALU_ADD;
      end
      5'd7: begin
        w.dst_ir = 1'b1; w.res = RES_K8;
      end
      5'd8: begin
        w.srca_ir = 1'b1; w.alu = ALU_DEC; w.reg_wr = 8'h40; w.res = RES_K4;
        w.nxt = NX_COUT; w.tgt_t = 5'd0; w.tgt_f = 5'd13;
      end
      5'd9: begin
        w.dst_ir = 1'b1; w.srca_ir = 1'b1; w.alu = ALU_PASS;
      end
      5'd10, 5'd11: begin
        w.srca_ir = 1'b1; w.alu = ALU_PASS; w.mar_ld = 1'b1;
        w.tgt_t = (addr_i == 5'd10) ? 5'd15 : 5'd18;
      end
      5'd12: begin
        w.dst_ir = 1'b1; w.srca_ir = 1'b1; w.srcb_ir = 1'b1;
        w.alu = ALU_SUB; w.cin = 1'b1;
      end
      5'd13: begin
        w.reg_wr = 8'h80; w.a_sel = 3'd7; w.b_sel = 3'd6; w.alu = ALU_ADD;
      end
      5'd15: begin  // r5 <- 0
        w.a_sel = 3'd5; w.b_sel = 3'd5; w.alu = ALU_SUB; w.cin = 1'b1;
        w.reg_wr = 8'h20; w.tgt_t = 5'd16;
      end
      5'd16: begin
        w.srcb_ir = 1'b1; w.a_sel = 3'd5; w.alu = ALU_OR; w.mdr = MDR_ALU;
        w.tgt_t = 5'd17;
      end
      5'd17: begin
        w.wr = 1'b1; w.nxt = NX_WAIT; w.tgt_t = 5'd17; w.tgt_f = 5'd0;
      end
      5'd18: begin
        w.rd = 1'b1; w.mdr = MDR_MEM; w.nxt = NX_WAIT; w.tgt_t = 5'd18; w.tgt_f = 5'd19;
      end
      5'd19: begin
        w.res = RES_MDR; w.dst_ir = 1'b1;
      end
      default: w = '0;  // 5, 14 and beyond: no controls, back to 0
    endcase
    if (32'(addr_i) >= DEPTH) w = '0;
  end

  assign word_o = w;
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
#(
  parameter int DEPTH     = 20,
  parameter int OPC_W     = 3,
  parameter int DISP_BASE = 5
) (
  input  uword_t          word_i,
  input  logic            mem_wait_i,
  input  logic            alu_cout_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UA_W-1:0] next_o
);
  localparam int NUM_ADDR = 2 ** UA_W;

  logic [UA_W-1:0] disp;
  logic [UA_W-1:0] raw;

  assign disp = UA_W'(DISP_BASE) + UA_W'(opcode_i);

  always_comb begin
    case (word_i.nxt)
      NX_GOTO: raw = word_i.tgt_t;
      NX_WAIT: raw = mem_wait_i ? word_i.tgt_t : word_i.tgt_f;
      NX_COUT: raw = alu_cout_i ? word_i.tgt_t : word_i.tgt_f;
      NX_DISP: raw = disp;
      default: raw = '0;
    endcase
  end

  generate
    if (DEPTH < NUM_ADDR) begin : g_guard
      assign next_o = (32'(raw) < DEPTH) ? raw : '0;
    end else begin : g_full
      assign next_o = raw;
    end
  endgenerate
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int DEPTH     = 20,
  parameter int OPC_W     = 3,
  parameter int DISP_BASE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mem_wait_i,
  input  logic             alu_cout_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [4:0]       upc_o,
  output logic [2:0]       a_sel_o,
  output logic [2:0]       b_sel_o,
  output logic [2:0]       alu_op_o,
  output logic             alu_cin_o,
  output logic [7:0]       reg_wr_o,
  output logic             dst_ir_o,
  output logic             srca_ir_o,
  output logic             srcb_ir_o,
  output logic             mar_ld_o,
  output logic [1:0]       mdr_src_o,
  output logic             ir_lo_ld_o,
  output logic             ir_hi_ld_o,
  output logic [1:0]       res_src_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o
);
  logic [UA_W-1:0] upc_q, upc_d;
  uword_t          word;

  mseq_store #(.DEPTH(DEPTH)) u_store (
    .addr_i (upc_q),
    .word_o (word)
  );

  mseq_next #(.DEPTH(DEPTH), .OPC_W(OPC_W), .DISP_BASE(DISP_BASE)) u_next (
    .word_i     (word),
    .mem_wait_i (mem_wait_i),
    .alu_cout_i (alu_cout_i),
    .opcode_i   (opcode_i),
    .next_o     (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o      = upc_q;
  assign a_sel_o    = word.a_sel;
  assign b_sel_o    = word.b_sel;
  assign alu_op_o   = word.alu;
  assign alu_cin_o  = word.cin;
  assign reg_wr_o   = word.reg_wr;
  assign dst_ir_o   = word.dst_ir;
  assign srca_ir_o  = word.srca_ir;
  assign srcb_ir_o  = word.srcb_ir;
  assign mar_ld_o   = word.mar_ld;
  assign mdr_src_o  = word.mdr;
  assign ir_lo_ld_o = word.ir_lo;
  assign ir_hi_ld_o = word.ir_hi;
  assign res_src_o  = word.res;
  assign mem_rd_o   = word.rd;
  assign mem_wr_o   = word.wr;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mem_wait_i,
  input logic       alu_cout_i,
  input logic [2:0] opcode_i,
  input logic [4:0] upc_o,
  input logic       ir_lo_ld_o,
  input logic       ir_hi_ld_o,
  input logic       mem_wr_o
);
  logic in_wait_word;
  assign in_wait_word = (upc_o == 5'd1) || (upc_o == 5'd3) ||
                        (upc_o == 5'd17) || (upc_o == 5'd18);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_ZERO: assert (upc_o == 5'd0); // R1
  end

  AST_FETCH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 5'd0) |=> (upc_o == 5'd1)); // R2
  AST_LOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_lo_ld_o, ir_hi_ld_o, mem_wr_o})); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait_word && mem_wait_i) |=> $stable(upc_o)); // R3
  AST_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 5'd4) |=> (upc_o == 5'd5 + 5'($past(opcode_i)))); // R4
  AST_BRZ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 5'd8 && !alu_cout_i) |=> (upc_o == 5'd13)); // R5
  AST_BRZ_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 5'd8 && alu_cout_i) |=> (upc_o == 5'd0)); // R5
  AST_UNUSED_HOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 5'd14) |=> (upc_o == 5'd0)); // R9
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o < 5'd20)); // R9
endmodule

bind mseq_top mseq_chk u_chk (.*);

// File: tb/mseq_top_bench.sv
`timescale 1ns/1ps
module mseq_top_bench;
  logic clk = 1'b0, rst_ni = 1'b0, mem_wait = 1'b0, alu_cout = 1'b0;
  logic [2:0] opcode = '0;
  logic [4:0] upc;
  logic [2:0] a_sel, b_sel, alu_op;
  logic alu_cin, dst_ir, srca_ir, srcb_ir, mar_ld, ir_lo, ir_hi, mem_rd, mem_wr;
  logic [7:0] reg_wr;
  logic [1:0] mdr_src, res_src;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  mseq_top u_mseq_top (
    .clk_i(clk), .rst_ni(rst_ni), .mem_wait_i(mem_wait), .alu_cout_i(alu_cout),
    .opcode_i(opcode), .upc_o(upc), .a_sel_o(a_sel), .b_sel_o(b_sel),
    .alu_op_o(alu_op), .alu_cin_o(alu_cin), .reg_wr_o(reg_wr), .dst_ir_o(dst_ir),
    .srca_ir_o(srca_ir), .srcb_ir_o(srcb_ir), .mar_ld_o(mar_ld), .mdr_src_o(mdr_src),
    .ir_lo_ld_o(ir_lo), .ir_hi_ld_o(ir_hi), .res_src_o(res_src),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr)
  );

  localparam int NV = 10;
  // opcode, cout, stall cycles per wait word, path length
  localparam int VEC [NV][4] = '{
    '{0, 0, 0, 6}, '{1, 0, 2, 6}, '{2, 1, 0, 6}, '{3, 1, 1, 6}, '{3, 0, 0, 7},
    '{4, 0, 3, 6}, '{5, 0, 2, 9}, '{6, 1, 1, 8}, '{7, 0, 0, 6}, '{5, 1, 0, 9}
  };
  localparam int PATH [NV][9] = '{
    '{0, 1, 2, 3, 4,  5,  0,  0,  0},
    '{0, 1, 2, 3, 4,  6,  0,  0,  0},
    '{0, 1, 2, 3, 4,  7,  0,  0,  0},
    '{0, 1, 2, 3, 4,  8,  0,  0,  0},
    '{0, 1, 2, 3, 4,  8, 13,  0,  0},
    '{0, 1, 2, 3, 4,  9,  0,  0,  0},
    '{0, 1, 2, 3, 4, 10, 15, 16, 17},
    '{0, 1, 2, 3, 4, 11, 18, 19,  0},
    '{0, 1, 2, 3, 4, 12,  0,  0,  0},
    '{0, 1, 2, 3, 4, 10, 15, 16, 17}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_fields(int a);
    case (a)
      0: chk("R1 fetch word", {a_sel, b_sel, alu_op, mar_ld, reg_wr}, {3'd7, 3'd7, 3'd4, 1'b1, 8'h40});
      1: chk("R2 low byte read", {mem_rd, ir_lo, ir_hi, alu_cin, reg_wr}, {1'b1, 1'b1, 1'b0, 1'b1, 8'h80});
      3: chk("R2 high byte read", {mem_rd, ir_lo, ir_hi, alu_cin, reg_wr}, {1'b1, 1'b0, 1'b1, 1'b1, 8'h80});
      5: chk("R9 no-op all zero", {a_sel, b_sel, alu_op, alu_cin, reg_wr, dst_ir, srca_ir, srcb_ir,
             mar_ld, mdr_src, ir_lo, ir_hi, res_src, mem_rd, mem_wr}, 0);
      6: chk("R8 add", {alu_op, dst_ir, srca_ir, srcb_ir}, {3'd0, 3'b111});
      7: chk("R8 const8", {res_src, dst_ir, srca_ir, srcb_ir}, {2'd1, 3'b100});
      8: chk("R5 brz word", {alu_op, res_src, srca_ir, reg_wr}, {3'd3, 2'd2, 1'b1, 8'h40});
      9: chk("R8 move", {alu_op, dst_ir, srca_ir, srcb_ir}, {3'd1, 3'b110});
      10, 11: chk("R6 R7 address load", {mar_ld, srca_ir, alu_op}, {1'b1, 1'b1, 3'd1});
      12: chk("R8 subtract", {alu_op, alu_cin, dst_ir, srca_ir, srcb_ir}, {3'd2, 4'b1111});
      13: chk("R5 branch add", {a_sel, b_sel, alu_op, reg_wr}, {3'd7, 3'd6, 3'd0, 8'h80});
      16: chk("R6 data to MDR", {mdr_src, srcb_ir, alu_op}, {2'd1, 1'b1, 3'd5});
      17: chk("R6 write word", {mem_wr, mem_rd}, {1'b1, 1'b0});
      18: chk("R7 read word", {mem_rd, mdr_src}, {1'b1, 2'd2});
      19: chk("R7 writeback", {res_src, dst_ir}, {2'd3, 1'b1});
      default: ;
    endcase
  endtask

  function automatic bit is_wait_word(int a);
    return a == 1 || a == 3 || a == 17 || a == 18;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2: watchdog expired, actual %0d expected 0", upc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset address", upc, 0);
    chk_fields(0);
    rst_ni = 1'b1;
    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      opcode   = 3'(VEC[v][0]);
      alu_cout = VEC[v][1][0];
      for (int i = 0; i < VEC[v][3]; i++) begin
        chk("R4 address trail", upc, PATH[v][i]);
        chk_fields(PATH[v][i]);
        if (is_wait_word(PATH[v][i]) && VEC[v][2] > 0) begin
          mem_wait = 1'b1;
          for (int k = 0; k < VEC[v][2]; k++) begin
            @(negedge clk);
            chk("R3 stall on wait", upc, PATH[v][i]);
          end
          mem_wait = 1'b0;
        end
        @(negedge clk);
      end
      chk("R8 return to fetch", upc, 0);
    end
    // R1: reset in the middle of fetch clears at once
    repeat (3) @(negedge clk);
    chk("R1 pre-reset position", upc, 3);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", upc, 0);
    @(negedge clk);
    chk("R1 held in reset", upc, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 restart fetch", upc, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule